// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This unit watches a 32-bit bus address and decides which of five external devices the access is meant for. Each channel has a base register and a mask register. The base register holds the top sixteen address bits. The mask register holds sixteen don't-care flags for those same bits, plus a write-protect flag, six access-type suppress flags and an enable flag. An address bit whose mask flag is set drops out of the comparison. A channel can therefore cover one power-of-two window of at least 64 KB, or several separate windows when the mask flags are not contiguous.

Each access starts with a one-cycle strobe that carries the address, a read/write flag and a one-hot access-type code. On the clock edge that samples the strobe, the unit registers the chip selects, which are active low. It holds them until the access-done input arrives. If several channels claim the same address, only the lowest-numbered one asserts. A write into a write-protected channel simply leaves that select inactive, with no error raised.

After reset only channel 0 is enabled. It has base 0 and every mask flag set, so it claims the whole address space and boot fetches can proceed.

Top module: `csd_top`

## Requirements
- R1: After reset all `cs_n` bits are high. Channel 0's base register reads 0x00000000 and its mask register reads 0xFFFF0001. Every other channel's registers read 0. With these values an access to any address asserts channel 0 only.
- R2: Register map:
  - Channel i's base register is at byte offset 0x80+12·i and its mask register at 0x84+12·i.
  - Base bits 31:16 are writable, and bits 15:0 read zero.
  - In the mask register, bits 31:16 are the don't-care flags, bit 8 is write protect, bits 6:1 are the type-suppress flags and bit 0 is enable.
  - Mask bits 15:9 and 7 read zero and ignore writes.
  - Offsets outside this map read zero.
- R3: A channel matches when every address bit 31:16 whose mask flag is clear equals the corresponding base bit. Non-contiguous flags select separate windows: base 0 with mask flags 0x0008 selects 0x0000xxxx and 0x0008xxxx, but not 0x0001xxxx or 0x0004xxxx.
- R4: Adjacent windows work. Base 0x0000 with flags 0x01FF covers 0x00000000–0x01FFFFFF (32 MB). Base 0x0200 with flags 0x00FF covers the next 16 MB.
- R5: When write protect is set, a write access inside the window leaves that channel's select high and no error output exists. A read in the same window selects the channel.
- R6: A channel whose enable bit is clear never asserts its select.
- R7: `acc_type` is one-hot: bit 5 = AM, bit 4 = C/I, bit 3 = SC, bit 2 = SD, bit 1 = UC, bit 0 = UD. Type-suppress flag bits 6:1 use the same order, so flag bit k+1 pairs with `acc_type[k]`. A set flag for the current type blocks the match.
- R8: At most one `cs_n` bit is low at any time. When several channels match, the lowest-numbered one wins.
- R9: Select timing:
  - `cs_n` updates on the clock edge that samples `acc_start` and stays unchanged until an edge that samples `acc_done`.
  - That edge drives all bits high.
  - When `acc_start` and `acc_done` are both high at the same edge, the new access wins.
- R10: An access that matches no channel leaves all `cs_n` bits high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| acc_start | input | 1 | One-cycle access strobe |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_type | input | 6 | One-hot access type |
| acc_done | input | 1 | Access completion; releases the selects |
| cs_n | output | 5 | Active-low chip selects, one per channel |

## Verification
The assertions take for granted that the write-protect and enable flags do not change at the edge that samples a strobe. They also assume that `acc_start` and `acc_done` are sampled only on clock edges, so a select changes only on a strobe or a completion. The stimulus changes registers only between accesses, with `acc_start` low. It applies every strobe and completion for exactly one cycle, driving them on the falling edge. It uses only one-hot `acc_type` values, because the type-suppress rule is defined only for a single access type.

// File: rtl/csd_pkg.sv
package csd_pkg;

  localparam int CMP_W    = 16;
  localparam int TYPE_W   = 6;
  localparam int REG_W    = 32;
  localparam int WP_BIT   = 8;
  localparam int EN_BIT   = 0;
  localparam int TM_LSB   = 1;

  typedef struct packed {
    logic [CMP_W-1:0]  base;
    logic [CMP_W-1:0]  mask;
    logic              wp;
    logic [TYPE_W-1:0] tmask;
    logic              en;
  } ch_cfg_t;

  // Channel 0 comes up enabled and open over the full space; the rest are off.
  function automatic ch_cfg_t cfg_reset(input int idx);
    ch_cfg_t c;
    c = '0;
    if (idx == 0) begin
      c.mask = '1;
      c.en   = 1'b1;
    end
    return c;
  endfunction

  function automatic logic [REG_W-1:0] mask_view(input ch_cfg_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[REG_W-1 -: CMP_W]               = c.mask;
    r[WP_BIT]                         = c.wp;
    r[TM_LSB + TYPE_W - 1 : TM_LSB]   = c.tmask;
    r[EN_BIT]                         = c.en;
    return r;
  endfunction

endpackage

// File: rtl/csd_regs.sv
module csd_regs
  import csd_pkg::*;
#(
  parameter int NUM_CH     = 5,
  parameter int OFF_W      = 8,
  parameter int MAP_BASE   = 'h80,
  parameter int MAP_STRIDE = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [OFF_W-1:0]    cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  output ch_cfg_t             cfg_q [NUM_CH]
);

  localparam int TM_MSB = TM_LSB + TYPE_W - 1;

  logic [REG_W-1:0] rd_part [NUM_CH];
  logic             wdata_unused;

  assign wdata_unused = ^{cfg_wdata[WP_BIT-1], cfg_wdata[REG_W-CMP_W-1:WP_BIT+1]};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [OFF_W-1:0] BASE_OFF = OFF_W'(MAP_BASE + MAP_STRIDE * i);
    localparam logic [OFF_W-1:0] MASK_OFF = OFF_W'(MAP_BASE + MAP_STRIDE * i + 4);

    logic    sel_base, sel_mask, wr_en;
    ch_cfg_t cfg_d;

    assign sel_base = (cfg_addr == BASE_OFF);
    assign sel_mask = (cfg_addr == MASK_OFF);
    assign wr_en    = cfg_we && (sel_base || sel_mask);

    always_comb begin
      cfg_d = cfg_q[i];
      if (sel_base) begin
        cfg_d.base = cfg_wdata[REG_W-1 -: CMP_W];
      end
      if (sel_mask) begin
        cfg_d.mask  = cfg_wdata[REG_W-1 -: CMP_W];
        cfg_d.wp    = cfg_wdata[WP_BIT];
        cfg_d.tmask = cfg_wdata[TM_MSB:TM_LSB];
        cfg_d.en    = cfg_wdata[EN_BIT];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= cfg_reset(i);
      end else if (wr_en) begin
        cfg_q[i] <= cfg_d;
      end
    end

    always_comb begin
      rd_part[i] = '0;
      if (sel_base) begin
        rd_part[i] = {cfg_q[i].base, {(REG_W-CMP_W){1'b0}}};
      end else if (sel_mask) begin
        rd_part[i] = mask_view(cfg_q[i]);
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      cfg_rdata = cfg_rdata | rd_part[i];
    end
  end

endmodule

// File: rtl/csd_match.sv
module csd_match
  import csd_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  ch_cfg_t              cfg [NUM_CH],
  input  logic [CMP_W-1:0]     addr_hi,
  input  logic                 acc_write,
  input  logic [TYPE_W-1:0]    acc_type,
  output logic [NUM_CH-1:0]    hit
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    logic addr_ok, type_ok, wp_ok;

    assign addr_ok = ((addr_hi ^ cfg[i].base) & ~cfg[i].mask) == '0;
    assign type_ok = (acc_type & cfg[i].tmask) == '0;
    assign wp_ok   = !(cfg[i].wp && acc_write);
    assign hit[i]  = cfg[i].en && addr_ok && type_ok && wp_ok;
  end

endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/csd_top.sv
module csd_top
  import csd_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OFF_W-1:0]  cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_start,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [5:0]        acc_type,
  input  logic              acc_done,
  output logic [NUM_CH-1:0] cs_n
);

  localparam int HI_LSB = ADDR_W - CMP_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  ch_cfg_t           cfg_q [NUM_CH];
  logic [NUM_CH-1:0] hit, gnt;
  logic [NUM_CH-1:0] sel_d, sel_q;
  logic              sel_en;
  logic [NUM_CH-1:0] ch_wp, ch_en;
  logic              addr_lo_unused;

  assign addr_lo_unused = ^acc_addr[HI_LSB-1:0];

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  csd_regs #(
    .NUM_CH (NUM_CH),
    .OFF_W  (OFF_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_q     (cfg_q)
  );

  csd_match #(
    .NUM_CH (NUM_CH)
  ) u_match (
    .cfg       (cfg_q),
    .addr_hi   (acc_addr[ADDR_W-1:HI_LSB]),
    .acc_write (acc_write),
    .acc_type  (acc_type),
    .hit       (hit)
  );

  csd_prio #(
    .N (NUM_CH)
  ) u_prio (
    .req (hit),
    .gnt (gnt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_flags
    assign ch_wp[i] = cfg_q[i].wp;
    assign ch_en[i] = cfg_q[i].en;
  end

  assign sel_en = acc_start || acc_done;

  always_comb begin
    sel_d = sel_q;
    if (acc_start) begin
      sel_d = gnt;
    end else if (acc_done) begin
      sel_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign cs_n = ~sel_q;

endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_start,
  input logic              acc_write,
  input logic              acc_done,
  input logic [NUM_CH-1:0] cs_n,
  input logic [NUM_CH-1:0] ch_wp,
  input logic [NUM_CH-1:0] ch_en
);

  p_single_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_start && !acc_done) |=> $stable(cs_n));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !acc_start) |=> (&cs_n));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    p_wp_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_start && acc_write && ch_wp[i]) |=> cs_n[i]);

    p_disabled_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_start && !ch_en[i]) |=> cs_n[i]);
  end

endmodule

bind csd_top csd_checker #(
  .NUM_CH (NUM_CH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_start (acc_start),
  .acc_write (acc_write),
  .acc_done  (acc_done),
  .cs_n      (cs_n),
  .ch_wp     (ch_wp),
  .ch_en     (ch_en)
);

// File: tb/test_csd_top.sv
module test_csd_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        acc_start;
  logic [31:0] acc_addr;
  logic        acc_write;
  logic [5:0]  acc_type;
  logic        acc_done;
  logic [4:0]  cs_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit over   = 0;

  localparam logic [5:0] T_AM = 6'b100000;
  localparam logic [5:0] T_UD = 6'b000001;
  localparam logic [4:0] NONE = 5'b11111;

  csd_top i_csd_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .acc_start (acc_start),
    .acc_addr  (acc_addr),
    .acc_write (acc_write),
    .acc_type  (acc_type),
    .acc_done  (acc_done),
    .cs_n      (cs_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  // Strobe one access, check the select after the sampling edge, then complete it.
  task automatic access(input string req, input logic [31:0] a, input logic wr,
                        input logic [5:0] ty, input logic [4:0] exp);
    @(negedge clk);
    acc_start = 1'b1; acc_addr = a; acc_write = wr; acc_type = ty;
    @(negedge clk);
    acc_start = 1'b0;
    check(req, {27'd0, cs_n}, {27'd0, exp});
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
    check({req, " release"}, {27'd0, cs_n}, {27'd0, NONE});
  endtask

  task automatic t_reset();
    check("R1 cs idle", {27'd0, cs_n}, {27'd0, NONE});
    reg_chk("R1 base0", 8'h80, 32'h0);
    reg_chk("R1 mask0", 8'h84, 32'hFFFF_0001);
    reg_chk("R1 base1", 8'h8C, 32'h0);
    reg_chk("R1 mask4", 8'hB4, 32'h0);
    access("R1 boot select", 32'h1234_5678, 1'b0, T_UD, 5'b11110);
  endtask

  task automatic t_regs();
    reg_wr(8'h8C, 32'hABCD_FFFF);
    reg_chk("R2 base reserved", 8'h8C, 32'hABCD_0000);
    reg_wr(8'h90, 32'hFFFF_FFFF);
    reg_chk("R2 mask reserved", 8'h90, 32'hFFFF_017F);
    reg_chk("R2 unmapped", 8'h88, 32'h0);
    reg_wr(8'h90, 32'h0);
    reg_wr(8'h8C, 32'h0);
  endtask

  task automatic t_noncontig();
    reg_wr(8'h84, 32'h0);
    reg_wr(8'h8C, 32'h0000_0000);
    reg_wr(8'h90, 32'h0008_0001);
    access("R3 low window", 32'h0000_1234, 1'b0, T_UD, 5'b11101);
    access("R3 high window", 32'h0008_FFFF, 1'b0, T_UD, 5'b11101);
    access("R3 gap", 32'h0004_0000, 1'b0, T_UD, NONE);
    access("R10 no match", 32'h0001_0000, 1'b0, T_UD, NONE);
  endtask

  task automatic t_contig();
    reg_wr(8'h90, 32'h01FF_0001);
    reg_wr(8'h98, 32'h0200_0000);
    reg_wr(8'h9C, 32'h00FF_0001);
    access("R4 top of 32MB", 32'h01FF_FFFF, 1'b0, T_UD, 5'b11101);
    access("R4 start of 16MB", 32'h0200_0000, 1'b0, T_UD, 5'b11011);
    access("R4 end of 16MB", 32'h02FF_FFFF, 1'b1, T_UD, 5'b11011);
    access("R4 beyond", 32'h0300_0000, 1'b0, T_UD, NONE);
  endtask

  task automatic t_wp();
    reg_wr(8'h9C, 32'h00FF_0101);
    access("R5 write blocked", 32'h0200_0010, 1'b1, T_UD, NONE);
    access("R5 read allowed", 32'h0200_0010, 1'b0, T_UD, 5'b11011);
  endtask

  task automatic t_enable();
    reg_wr(8'h9C, 32'h00FF_0000);
    access("R6 disabled", 32'h0200_0000, 1'b0, T_UD, NONE);
  endtask

  task automatic t_type();
    reg_wr(8'hA4, 32'h4000_0000);
    reg_wr(8'hA8, 32'h0000_0041);
    access("R7 AM suppressed", 32'h4000_0000, 1'b0, T_AM, NONE);
    access("R7 UD allowed", 32'h4000_0000, 1'b0, T_UD, 5'b10111);
  endtask

  task automatic t_prio();
    reg_wr(8'hA8, 32'h0000_0001);
    reg_wr(8'hB0, 32'h4000_0000);
    reg_wr(8'hB4, 32'h0000_0001);
    access("R8 lowest wins", 32'h4000_0000, 1'b0, T_UD, 5'b10111);
    reg_wr(8'hA8, 32'h0);
    access("R8 next channel", 32'h4000_0000, 1'b0, T_UD, 5'b01111);
  endtask

  task automatic t_timing();
    @(negedge clk);
    acc_start = 1'b1; acc_addr = 32'h4000_0000; acc_write = 1'b0; acc_type = T_UD;
    #1;
    check("R9 not before edge", {27'd0, cs_n}, {27'd0, NONE});
    @(negedge clk);
    acc_start = 1'b0;
    check("R9 after strobe edge", {27'd0, cs_n}, {27'd0, 5'b01111});
    repeat (3) @(negedge clk);
    check("R9 held", {27'd0, cs_n}, {27'd0, 5'b01111});
    acc_start = 1'b1; acc_done = 1'b1; acc_addr = 32'h0000_0000;
    @(negedge clk);
    acc_start = 1'b0;
    check("R9 start beats done", {27'd0, cs_n}, {27'd0, 5'b11101});
    @(negedge clk);
    acc_done = 1'b0;
    check("R9 done releases", {27'd0, cs_n}, {27'd0, NONE});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9: watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    acc_start = 1'b0; acc_addr = '0; acc_write = 1'b0; acc_type = T_UD; acc_done = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_noncontig();
    t_contig();
    t_wp();
    t_enable();
    t_type();
    t_prio();
    t_timing();
    finish_run();
  end

endmodule